// File: doc/BRIEF.md
# Nonvolatile Shadow Memory Controller

This controller manages a small static RAM array with a shadow nonvolatile array behind it. On the functional port side it acts as a plain RAM: a chip enable, a write enable, an address and a data bus. Behind that port it moves the whole array between the two copies. It saves the RAM into the shadow copy when software asks for it, or on its own when the supply is failing. It refills the RAM from the shadow copy every time the supply comes back. Both arrays are register arrays. The save time and the restore time are set by parameters.

Two digital flags from the supply monitor drive the sequence. `vsw_ok` is high while the supply is above the switch threshold. `vrst_low` is high while the supply is below the reset threshold. A reset of the controller, or `vrst_low` in any state, leaves a restore pending. The restore runs as soon as `vsw_ok` is high and `vrst_low` is low.

The restore has two phases. First it writes zero to every RAM word, one word per clock. Then it copies the shadow array in, one word per clock, and waits until its full length has passed. A save copies RAM into the shadow array one word per clock and then waits until the store length has passed. A dirty bit follows writes. An automatic save when the supply falls runs only if the RAM was written since the last save or restore.

States and transitions (`state_o` code in brackets):
- `ST_DOWN` [0]. Restore pending. Goes to `ST_CLEAR` when `vsw_ok`=1 and `vrst_low`=0.
- `ST_CLEAR` [1]. Zero-fill, DEPTH cycles. Then goes to `ST_LOAD`.
- `ST_LOAD` [2]. Copy-in and wait, RESTORE_CYC−DEPTH cycles. Then goes to `ST_READY`.
- `ST_READY` [3]. Normal access. Goes to `ST_SAVE` on a software store or on an automatic store.
- `ST_SAVE` [4]. Copy-out and wait, STORE_CYC cycles. Then goes back to `ST_READY`.
- From any state, `vrst_low` forces `ST_DOWN`.

Top module: `nvshadow_ctrl`

## Requirements
- R1: While `rst_n` is low and afterwards, `state_o` is 0 (ST_DOWN) with `busy`=1. It stays there until a clock edge sees `vsw_ok`=1 and `vrst_low`=0, and then it enters 1 (ST_CLEAR).
- R2: A restore spends exactly DEPTH cycles in state 1 (ST_CLEAR), then exactly RESTORE_CYC−DEPTH cycles in state 2 (ST_LOAD), then enters 3 (ST_READY).
- R3: After a restore, every RAM word equals the shadow word saved last, or zero if nothing was ever saved. A restore leaves the shadow array unchanged, so repeated restores return the same data.
- R4: A clock edge that sees `vrst_low`=1 puts the controller in state 0 (ST_DOWN) on the next cycle, whatever state it was in.
- R5: In state 3 with `vsw_ok`=1, `ce`=1 and `we`=1, the word at `addr` takes `wdata` at the clock edge. With `ce`=1 and `we`=0, `rdata` shows the word at `addr` in the same cycle. Otherwise `rdata` is 0.
- R6: While `vsw_ok`=0, RAM writes and `sw_store` requests have no effect.
- R7: A `sw_store` pulse seen in state 3 with `vsw_ok`=1 enters state 4 (ST_SAVE), even when no write has happened. The save lasts exactly STORE_CYC cycles, copies every RAM word into the shadow array and then returns to state 3.
- R8: A fall of `vsw_ok` seen in state 3 starts a save (state 4) only if a write has been accepted since the last completed save or restore. Otherwise the state stays 3.
- R9: The dirty condition is cleared when a save or a restore completes, so a fall of `vsw_ok` right after a save starts no new save.
- R10: `busy` is 1 in every state except 3. While busy, `rdata` is 0 and writes are ignored.
- R11: `corrupt` is set when a restore ends while `ce`=1 and `we`=1. It is cleared when the next restore starts, and it holds its value while in state 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| vsw_ok | input | 1 | Supply above switch threshold |
| vrst_low | input | 1 | Supply below reset threshold |
| ce | input | 1 | Chip enable |
| we | input | 1 | Write enable (with `ce`) |
| sw_store | input | 1 | Software store request |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, 0 when not reading |
| busy | output | 1 | High outside ST_READY |
| state_o | output | 3 | Current state code |
| corrupt | output | 1 | Write was active at restore end |

## Verification
On every cycle, the assertions check the legal state transitions: where the zero-fill, copy-in and save phases may be entered from and left to, and that `vrst_low` forces ST_DOWN. They also check that `rdata` is zero while busy and that `corrupt` holds its value in ST_READY. Some properties depend on the data in the arrays, and only the bench scenarios can show them. These are that a restore brings back the last saved contents, that writes and store requests during low supply or while busy are lost, that the dirty bit gates the automatic save, and that each phase lasts the exact cycle count.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    typedef enum logic [2:0] {
        ST_DOWN  = 3'd0,
        ST_CLEAR = 3'd1,
        ST_LOAD  = 3'd2,
        ST_READY = 3'd3,
        ST_SAVE  = 3'd4
    } nvs_state_t;
endpackage

// File: rtl/nvs_array.sv
module nvs_array #(
    parameter int DW         = 8,
    parameter int DEPTH      = 16,
    parameter bit CLR_ON_RST = 1'b0,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    generate
        if (CLR_ON_RST) begin : g_blank
            // shadow copy starts blank after a controller reset
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
                end else if (wr_en) begin
                    mem[waddr] <= wdata;
                end
            end
        end else begin : g_plain
            // volatile copy: contents are established by the restore sequence
            logic unused_rst;
            assign unused_rst = rst_n;
            always_ff @(posedge clk) begin
                if (wr_en) mem[waddr] <= wdata;
            end
        end
    endgenerate

    assign rdata = mem[raddr];
endmodule

// File: rtl/nvs_fsm.sv
module nvs_fsm
    import nvs_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int STORE_CYC   = 24,
    parameter int RESTORE_CYC = 40,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vsw_ok,
    input  logic          vrst_low,
    input  logic          ce,
    input  logic          we,
    input  logic          sw_store,
    output nvs_state_t    state,
    output logic [AW-1:0] idx,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic          clr_we,
    output logic          load_we,
    output logic          save_we,
    output logic          busy,
    output logic          corrupt
);
    localparam int CMAX = (STORE_CYC > RESTORE_CYC) ? STORE_CYC : RESTORE_CYC;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] CLR_LAST  = CW'(DEPTH - 1);
    localparam logic [CW-1:0] LOAD_LAST = CW'(RESTORE_CYC - DEPTH - 1);
    localparam logic [CW-1:0] SAVE_LAST = CW'(STORE_CYC - 1);
    localparam logic [CW-1:0] DEPTH_C   = CW'(DEPTH);

    nvs_state_t    nxt;
    logic [CW-1:0] cnt;
    logic          vsw_q;
    logic          dirty;
    logic          auto_go;
    logic          sw_go;

    assign auto_go = vsw_q & ~vsw_ok & dirty;
    assign sw_go   = sw_store & vsw_ok;

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_DOWN:  if (vsw_ok && !vrst_low) nxt = ST_CLEAR;
            ST_CLEAR: if (cnt == CLR_LAST)     nxt = ST_LOAD;
            ST_LOAD:  if (cnt == LOAD_LAST)    nxt = ST_READY;
            ST_READY: if (auto_go || sw_go)    nxt = ST_SAVE;
            ST_SAVE:  if (cnt == SAVE_LAST)    nxt = ST_READY;
            default:                           nxt = ST_DOWN;
        endcase
        if (vrst_low) nxt = ST_DOWN;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_DOWN;
        else        state <= nxt;
    end

    // phase counter, supply history, dirty and corruption flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            vsw_q   <= 1'b0;
            dirty   <= 1'b0;
            corrupt <= 1'b0;
        end else begin
            vsw_q <= vsw_ok;
            if (nxt != state || state == ST_READY || state == ST_DOWN) cnt <= '0;
            else                                                       cnt <= cnt + 1'b1;
            if (wr_ok)
                dirty <= 1'b1;
            else if (nxt == ST_READY && (state == ST_SAVE || state == ST_LOAD))
                dirty <= 1'b0;
            if (state == ST_DOWN && nxt == ST_CLEAR)
                corrupt <= 1'b0;
            else if (state == ST_LOAD && nxt == ST_READY && ce && we)
                corrupt <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_READY);
        wr_ok   = (state == ST_READY) && vsw_ok && ce && we;
        rd_ok   = (state == ST_READY) && ce && !we;
        clr_we  = (state == ST_CLEAR);
        load_we = (state == ST_LOAD) && (cnt < DEPTH_C);
        save_we = (state == ST_SAVE) && (cnt < DEPTH_C);
        idx     = cnt[AW-1:0];
    end
endmodule

// File: rtl/nvshadow_ctrl.sv
module nvshadow_ctrl
    import nvs_pkg::*;
#(
    parameter int DW          = 8,
    parameter int DEPTH       = 16,
    parameter int STORE_CYC   = 24,
    parameter int RESTORE_CYC = 40,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vsw_ok,
    input  logic          vrst_low,
    input  logic          ce,
    input  logic          we,
    input  logic          sw_store,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          busy,
    output logic [2:0]    state_o,
    output logic          corrupt
);
    nvs_state_t    st;
    logic [AW-1:0] idx;
    logic          wr_ok, rd_ok, clr_we, load_we, save_we;
    logic          ram_we;
    logic [AW-1:0] ram_waddr, ram_raddr;
    logic [DW-1:0] ram_wdata, ram_rd, nv_rd;

    nvs_fsm #(
        .DEPTH      (DEPTH),
        .STORE_CYC  (STORE_CYC),
        .RESTORE_CYC(RESTORE_CYC)
    ) i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .vsw_ok  (vsw_ok),
        .vrst_low(vrst_low),
        .ce      (ce),
        .we      (we),
        .sw_store(sw_store),
        .state   (st),
        .idx     (idx),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok),
        .clr_we  (clr_we),
        .load_we (load_we),
        .save_we (save_we),
        .busy    (busy),
        .corrupt (corrupt)
    );

    assign ram_we    = wr_ok | clr_we | load_we;
    assign ram_waddr = wr_ok ? addr : idx;
    assign ram_wdata = wr_ok ? wdata : (load_we ? nv_rd : '0);
    assign ram_raddr = (st == ST_SAVE) ? idx : addr;

    nvs_array #(.DW(DW), .DEPTH(DEPTH), .CLR_ON_RST(1'b0)) i_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(ram_we),
        .waddr(ram_waddr),
        .wdata(ram_wdata),
        .raddr(ram_raddr),
        .rdata(ram_rd)
    );

    nvs_array #(.DW(DW), .DEPTH(DEPTH), .CLR_ON_RST(1'b1)) i_nv (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(save_we),
        .waddr(idx),
        .wdata(ram_rd),
        .raddr(idx),
        .rdata(nv_rd)
    );

    assign rdata   = rd_ok ? ram_rd : '0;
    assign state_o = st;
endmodule

// File: rtl/nvs_checker.sv
module nvs_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          vsw_ok,
    input logic          vrst_low,
    input logic [2:0]    state_o,
    input logic          busy,
    input logic [DW-1:0] rdata,
    input logic          corrupt
);
    p_entry_from_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && $past(state_o) != 3'd1) |->
        ($past(state_o) == 3'd0 && $past(vsw_ok) && !$past(vrst_low)));

    p_load_after_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2) |-> ($past(state_o) == 3'd1 || $past(state_o) == 3'd2));

    p_ready_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && $past(state_o) != 3'd3) |->
        ($past(state_o) == 3'd2 || $past(state_o) == 3'd4));

    p_brownout_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vrst_low |=> (state_o == 3'd0));

    p_save_from_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && $past(state_o) != 3'd4) |-> ($past(state_o) == 3'd3));

    p_lowv_save_needs_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && $past(state_o) == 3'd3 && !$past(vsw_ok)) |-> $past(vsw_ok, 2));

    p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rdata == '0));

    p_corrupt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && $past(state_o) == 3'd3) |-> $stable(corrupt));
endmodule

bind nvshadow_ctrl nvs_checker #(.DW(DW)) i_nvs_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .vsw_ok  (vsw_ok),
    .vrst_low(vrst_low),
    .state_o (state_o),
    .busy    (busy),
    .rdata   (rdata),
    .corrupt (corrupt)
);

// File: tb/test_nvshadow_ctrl.sv
module test_nvshadow_ctrl;
    localparam int CLK_PERIOD  = 10;
    localparam int DW          = 8;
    localparam int DEPTH       = 16;
    localparam int STORE_CYC   = 24;
    localparam int RESTORE_CYC = 40;
    localparam int AW          = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vsw_ok = 1'b0, vrst_low = 1'b0, ce = 1'b0, we = 1'b0, sw_store = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic busy, corrupt;
    logic [2:0] state_o;

    int n_chk = 0, n_fail = 0;
    logic [DW-1:0] ram_m [DEPTH];
    logic [DW-1:0] nv_m  [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    nvshadow_ctrl #(.DW(DW), .DEPTH(DEPTH), .STORE_CYC(STORE_CYC), .RESTORE_CYC(RESTORE_CYC))
    i_nvshadow_ctrl (
        .clk(clk), .rst_n(rst_n), .vsw_ok(vsw_ok), .vrst_low(vrst_low), .ce(ce), .we(we),
        .sw_store(sw_store), .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy),
        .state_o(state_o), .corrupt(corrupt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "WDOG", 0, 1, "watchdog expired");
        summary();
        $finish;
    end

    // assumes state 0; raises vsw_ok and measures the two restore phases (R2)
    task automatic run_restore(input string tag);
        int c1 = 0, c2 = 0, lim = 0;
        @(negedge clk); vsw_ok = 1'b1;
        do begin
            @(negedge clk);
            if (state_o == 3'd1) c1++;
            if (state_o == 3'd2) c2++;
            lim++;
        end while (state_o != 3'd3 && lim < 400);
        chk(c1 == DEPTH, "R2", c1, DEPTH, {tag, " clear cycles"});
        chk(c2 == RESTORE_CYC - DEPTH, "R2", c2, RESTORE_CYC - DEPTH, {tag, " load cycles"});
        for (int i = 0; i < DEPTH; i++) ram_m[i] = nv_m[i];
    endtask

    task automatic brownout(input string tag);
        @(negedge clk); vrst_low = 1'b1; vsw_ok = 1'b0;
        @(negedge clk);
        chk(state_o == 3'd0, "R4", state_o, 0, {tag, " state after vrst_low"});
        vrst_low = 1'b0;
        run_restore(tag);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk); ce = 1'b1; we = 1'b1; addr = AW'(a); wdata = DW'(d);
        @(negedge clk); ce = 1'b0; we = 1'b0;
    endtask

    task automatic rd_chk(input int a, input int exp, input string req);
        @(negedge clk); ce = 1'b1; we = 1'b0; addr = AW'(a);
        #1 chk(rdata == DW'(exp), req, rdata, exp, $sformatf("read addr %0d", a));
        ce = 1'b0;
    endtask

    task automatic chk_all(input string req);
        for (int i = 0; i < DEPTH; i++) rd_chk(i, ram_m[i], req);
    endtask

    task automatic sw_save(input string tag);
        int n = 0;
        @(negedge clk); sw_store = 1'b1;
        @(negedge clk); sw_store = 1'b0;
        chk(state_o == 3'd4, "R7", state_o, 4, {tag, " save entered"});
        while (state_o == 3'd4 && n < 400) begin n++; @(negedge clk); end
        chk(n == STORE_CYC, "R7", n, STORE_CYC, {tag, " save length"});
        for (int i = 0; i < DEPTH; i++) nv_m[i] = ram_m[i];
    endtask

    task automatic t_reset();
        #1;
        chk(state_o == 3'd0 && busy == 1'b1, "R1", state_o, 0, "state in reset");
        chk(corrupt == 1'b0, "R11", corrupt, 0, "corrupt in reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(state_o == 3'd0, "R1", state_o, 0, "waits for supply");
    endtask

    task automatic t_powerup();
        for (int i = 0; i < DEPTH; i++) nv_m[i] = '0;
        run_restore("powerup");
        chk(busy == 1'b0, "R10", busy, 0, "ready not busy");
        chk_all("R3");
    endtask

    task automatic t_rw();
        for (int i = 0; i < DEPTH; i++) begin wr(i, i * 7 + 3); ram_m[i] = DW'(i * 7 + 3); end
        chk_all("R5");
        @(negedge clk); ce = 1'b0; we = 1'b0; addr = AW'(2);
        #1 chk(rdata == '0, "R5", rdata, 0, "rdata without ce");
    endtask

    task automatic t_sw_store_restore();
        sw_save("swstore");
        for (int i = 0; i < 4; i++) begin wr(i, 8'hA0 + i); ram_m[i] = DW'(8'hA0 + i); end
        rd_chk(1, 8'hA1, "R5");
        brownout("restore1");
        chk_all("R3");
        brownout("restore2");
        chk_all("R3");
    endtask

    task automatic t_clean_lowv();
        @(negedge clk); vsw_ok = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk(state_o == 3'd3, "R8", state_o, 3, "no save when clean");
        end
        wr(1, 8'h55);
        rd_chk(1, ram_m[1], "R6");
        @(negedge clk); sw_store = 1'b1;
        @(negedge clk); sw_store = 1'b0;
        chk(state_o == 3'd3, "R6", state_o, 3, "sw_store at low supply");
        @(negedge clk); vsw_ok = 1'b1;
    endtask

    task automatic t_auto_store();
        int n = 1;
        wr(2, 8'h77); ram_m[2] = 8'h77;
        @(negedge clk); vsw_ok = 1'b0;
        @(negedge clk);
        chk(state_o == 3'd4, "R8", state_o, 4, "auto save when dirty");
        while (n < 400) begin @(negedge clk); if (state_o != 3'd4) break; n++; end
        chk(n == STORE_CYC, "R7", n, STORE_CYC, "auto save length");
        for (int i = 0; i < DEPTH; i++) nv_m[i] = ram_m[i];
        wr(2, 8'h11);
        brownout("after auto");
        chk_all("R8");
    endtask

    task automatic t_dirty_clear();
        wr(4, 8'h3C); ram_m[4] = 8'h3C;
        sw_save("dirty");
        @(negedge clk); vsw_ok = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(state_o == 3'd3, "R9", state_o, 3, "no save after save");
        end
        @(negedge clk); vsw_ok = 1'b1;
        sw_save("clean sw");
    endtask

    task automatic t_busy();
        int lim = 0;
        @(negedge clk); vrst_low = 1'b1; vsw_ok = 1'b0;
        @(negedge clk); vrst_low = 1'b0; vsw_ok = 1'b1;
        ce = 1'b1; we = 1'b0; addr = AW'(4);
        @(negedge clk); #1;
        chk(rdata == '0 && busy == 1'b1, "R10", rdata, 0, "read while busy");
        ce = 1'b0;
        while (!(state_o == 3'd2) && lim < 400) begin @(negedge clk); lim++; end
        repeat (DEPTH + 2) @(negedge clk);
        ce = 1'b1; we = 1'b1; addr = AW'(3); wdata = 8'hEE;
        @(negedge clk); ce = 1'b0; we = 1'b0;
        lim = 0;
        while (state_o != 3'd3 && lim < 400) begin @(negedge clk); lim++; end
        for (int i = 0; i < DEPTH; i++) ram_m[i] = nv_m[i];
        rd_chk(3, ram_m[3], "R10");
    endtask

    task automatic t_corrupt();
        int lim = 0;
        @(negedge clk); vrst_low = 1'b1; vsw_ok = 1'b0;
        @(negedge clk); vrst_low = 1'b0; vsw_ok = 1'b1;
        ce = 1'b1; we = 1'b1; addr = AW'(5); wdata = 8'h99;
        while (state_o != 3'd3 && lim < 400) begin @(negedge clk); lim++; end
        ce = 1'b0; we = 1'b0;
        for (int i = 0; i < DEPTH; i++) ram_m[i] = nv_m[i];
        chk(corrupt == 1'b1, "R11", corrupt, 1, "write active at restore end");
        repeat (3) @(negedge clk);
        chk(corrupt == 1'b1, "R11", corrupt, 1, "corrupt held in ready");
        rd_chk(5, ram_m[5], "R10");
        brownout("clean");
        chk(corrupt == 1'b0, "R11", corrupt, 0, "cleared by new restore");
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_rw();
        t_sw_store_restore();
        t_clean_lowv();
        t_auto_store();
        t_dirty_clear();
        t_busy();
        t_corrupt();
        summary();
        $finish;
    end
endmodule